// File: doc/BRIEF.md
# Adaptive 4-bit Differential Sample Decoder

This block expands a stream of 4-bit adaptive differential codes into signed 16-bit PCM samples. Each accepted code moves the running sample up or down by an amount taken from a per-code odd weight of the current quantizer step. The step then adapts by a fixed multiplier chosen by the code's magnitude, and is held inside a fixed window. The block keeps two words of state: the last sample and the step size.

Codes arrive packed two to a byte. The caller presents the byte with a parity flag, which is the low bit of the sample address, and the block selects the nibble itself. A restart input returns the state to its initial values, for instance when a looped stream jumps back to its start. Memory fetch, interpolation and volume are left to the surrounding logic.

Top module: `adpcm_nibble_decoder`

## Requirements
- R1: With `in_odd` low the code is bits 3:0 of `in_byte`; with `in_odd` high it is bits 7:4.
- R2: In a code, bit 3 is the sign (1 means subtract) and bits 2:0 form an index i. The difference is floor(step*(2i+1)/8), capped at 32767 before the sign is applied.
- R3: The new sample is the previous sample plus or minus the difference, saturated to -32768..32767.
- R4: The new step is floor(step*m/256), with m = 230 for indices 0..3, and 307, 409, 512, 614 for indices 4, 5, 6, 7.
- R5: After every update the step is clamped to the range 127..24576.
- R6: A high `restart` sets the step to 127 and the previous sample to 0, takes priority over a code in the same cycle, and yields no output valid in the cycle after.
- R7: An accepted code (`in_valid` high, `restart` low) drives `out_valid` high with its sample on `out_sample` exactly one clock later; otherwise `out_valid` is low.
- R8: Without an accepted code or restart the state and `out_sample` hold their values.
- R9: A synchronous `rst` clears `out_valid` and `out_sample` to 0 and sets the state as a restart does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous state clear, priority over a code |
| in_valid | input | 1 | A code is offered this cycle |
| in_byte | input | 8 | Byte holding two packed codes |
| in_odd | input | 1 | Sample address parity, selects the nibble |
| out_valid | output | 1 | Decoded sample present |
| out_sample | output | 16 | Decoded signed sample |

## Verification
Every result of this block is due one clock after the edge that accepts the code, restart or reset: the sample, its valid flag and the cleared state all come from a single register stage. The bench drives inputs on the falling edge, lets one rising edge pass and reads the outputs two nanoseconds later, comparing them against a bench model updated at the same point. The step size is never read directly; its adaptation and clamping are judged from the samples that later codes produce.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int CODE_W     = 4;
    localparam int IDX_W      = CODE_W - 1;
    localparam int STEP_MIN   = 127;
    localparam int STEP_MAX   = 24576;
    localparam int STEP_W     = $clog2(STEP_MAX + 1);
    localparam int MUL_W      = 10;
    localparam int MUL_SHIFT  = 8;
    localparam int WGT_W      = IDX_W + 1;
    localparam int WGT_SHIFT  = 3;
    localparam int SAMPLE_MAX = (1 << (SAMPLE_W - 1)) - 1;
    localparam int SAMPLE_MIN = -SAMPLE_MAX - 1;

    typedef struct packed {
        logic             neg;
        logic [IDX_W-1:0] idx;
    } code_t;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] sample;
        logic        [STEP_W-1:0]   step;
    } dec_state_t;

    function automatic logic [MUL_W-1:0] step_mult(input logic [IDX_W-1:0] idx);
        logic [MUL_W-1:0] m;
        case (idx)
            3'd4:    m = MUL_W'(307);
            3'd5:    m = MUL_W'(409);
            3'd6:    m = MUL_W'(512);
            3'd7:    m = MUL_W'(614);
            default: m = MUL_W'(230);
        endcase
        return m;
    endfunction

    function automatic logic [WGT_W-1:0] odd_weight(input logic [IDX_W-1:0] idx);
        return {idx, 1'b1};
    endfunction

endpackage

// File: rtl/adpcm_nibble_pick.sv
module adpcm_nibble_pick
    import adpcm_pkg::*;
#(
    parameter int BYTE_W = 2 * CODE_W
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              odd_i,
    output code_t             code_o
);
    localparam int NIBBLES = BYTE_W / CODE_W;

    logic [CODE_W-1:0] lanes [NIBBLES];

    for (genvar g = 0; g < NIBBLES; g++) begin : g_lane
        assign lanes[g] = byte_i[g*CODE_W +: CODE_W];
    end

    always_comb begin
        code_o = code_t'(lanes[0]);
        if (odd_i) code_o = code_t'(lanes[NIBBLES-1]);
    end
endmodule

// File: rtl/adpcm_step_calc.sv
module adpcm_step_calc
    import adpcm_pkg::*;
(
    input  dec_state_t cur_i,
    input  code_t      code_i,
    output dec_state_t nxt_o
);
    localparam int WP_W  = STEP_W + WGT_W;
    localparam int MP_W  = STEP_W + MUL_W;
    localparam int SUM_W = SAMPLE_W + 2;

    localparam logic [WP_W-1:0]         DIFF_CAP = WP_W'(SAMPLE_MAX);
    localparam logic [MP_W-1:0]         STEP_HI  = MP_W'(STEP_MAX);
    localparam logic [MP_W-1:0]         STEP_LO  = MP_W'(STEP_MIN);
    localparam logic signed [SUM_W-1:0] SAT_HI   = SUM_W'(SAMPLE_MAX);
    localparam logic signed [SUM_W-1:0] SAT_LO   = SUM_W'(SAMPLE_MIN);

    logic [WP_W-1:0]         wprod, wshift;
    logic [SAMPLE_W-1:0]     diff;
    logic [MP_W-1:0]         mprod, mshift;
    logic signed [SUM_W-1:0] ext_prev, ext_diff, total;

    always_comb begin
        wprod  = {{WGT_W{1'b0}}, cur_i.step} * {{STEP_W{1'b0}}, odd_weight(code_i.idx)};
        wshift = wprod >> WGT_SHIFT;
        diff   = (wshift > DIFF_CAP) ? DIFF_CAP[SAMPLE_W-1:0] : wshift[SAMPLE_W-1:0];
    end

    always_comb begin
        ext_prev = {{2{cur_i.sample[SAMPLE_W-1]}}, cur_i.sample};
        ext_diff = signed'({2'b00, diff});
        total    = code_i.neg ? (ext_prev - ext_diff) : (ext_prev + ext_diff);
        if (total > SAT_HI)      nxt_o.sample = SAT_HI[SAMPLE_W-1:0];
        else if (total < SAT_LO) nxt_o.sample = SAT_LO[SAMPLE_W-1:0];
        else                     nxt_o.sample = total[SAMPLE_W-1:0];
    end

    always_comb begin
        mprod  = {{MUL_W{1'b0}}, cur_i.step} * {{STEP_W{1'b0}}, step_mult(code_i.idx)};
        mshift = mprod >> MUL_SHIFT;
        if (mshift > STEP_HI)      nxt_o.step = STEP_HI[STEP_W-1:0];
        else if (mshift < STEP_LO) nxt_o.step = STEP_LO[STEP_W-1:0];
        else                       nxt_o.step = mshift[STEP_W-1:0];
    end
endmodule

// File: rtl/adpcm_nibble_decoder.sv
module adpcm_nibble_decoder
    import adpcm_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       restart,
    input  logic                       in_valid,
    input  logic [2*CODE_W-1:0]        in_byte,
    input  logic                       in_odd,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_sample
);
    code_t      code;
    dec_state_t cur_q, nxt;
    logic       accept;

    assign accept = in_valid & ~restart;

    adpcm_nibble_pick u_pick (
        .byte_i (in_byte),
        .odd_i  (in_odd),
        .code_o (code)
    );

    adpcm_step_calc u_calc (
        .cur_i  (cur_q),
        .code_i (code),
        .nxt_o  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cur_q.sample <= '0;
            cur_q.step   <= STEP_W'(STEP_MIN);
            out_valid    <= 1'b0;
            if (rst) out_sample <= '0;
        end else if (accept) begin
            cur_q      <= nxt;
            out_valid  <= 1'b1;
            out_sample <= nxt.sample;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R7: valid appears one cycle after an accepted code
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);
    // R6: restart returns the state to its initial values
    a_r6_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cur_q.sample == '0 && cur_q.step == STEP_W'(STEP_MIN)));
    // R8: idle cycles hold the state and the output
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !restart) |=> ($stable(out_sample) && $stable(cur_q)));
    // R3: a positive code never lowers the sample
    a_r3_positive_rises: assert property (@(posedge clk) disable iff (rst)
        (accept && !code.neg) |=> (out_sample >= $past(cur_q.sample)));
    // R5: step stays inside its window
    a_r5_step_window: assert property (@(posedge clk) disable iff (rst)
        (cur_q.step >= STEP_W'(STEP_MIN) && cur_q.step <= STEP_W'(STEP_MAX)));
endmodule

// File: tb/adpcm_nibble_decoder_bench.sv
module adpcm_nibble_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_odd = 1'b0;
    logic        out_valid;
    logic signed [15:0] out_sample;

    int n_tests = 0;
    int n_fail  = 0;
    int m_prev  = 0;
    int m_step  = 127;
    int last_out = 0;

    always #5 clk = ~clk;

    adpcm_nibble_decoder u_adpcm_nibble_decoder (
        .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
        .in_byte(in_byte), .in_odd(in_odd),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int mult_of(int idx);
        case (idx)
            4: return 307;
            5: return 409;
            6: return 512;
            7: return 614;
            default: return 230;
        endcase
    endfunction

    function automatic void model_code(int nib);
        int idx = nib & 7;
        int d   = (m_step * (2 * idx + 1)) >> 3;
        int s;
        if (d > 32767) d = 32767;
        s = ((nib & 8) != 0) ? m_prev - d : m_prev + d;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        m_prev = s;
        m_step = (m_step * mult_of(idx)) >> 8;
        if (m_step > 24576) m_step = 24576;
        if (m_step < 127)   m_step = 127;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] b, input logic odd, input logic v,
                        input logic rs, input string tag);
        int nib;
        @(negedge clk);
        in_byte = b; in_odd = odd; in_valid = v; restart = rs;
        @(posedge clk);
        #2;
        nib = odd ? int'(b[7:4]) : int'(b[3:0]);
        if (rs) begin
            m_prev = 0; m_step = 127;
            check({tag, " valid"}, int'(out_valid), 0);
            check({tag, " hold"}, int'(out_sample), last_out);
        end else if (v) begin
            model_code(nib);
            last_out = m_prev;
            check({tag, " valid"}, int'(out_valid), 1);
            check({tag, " sample"}, int'(out_sample), m_prev);
        end else begin
            check({tag, " valid"}, int'(out_valid), 0);
            check({tag, " hold"}, int'(out_sample), last_out);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; restart = 1'b0;
        @(posedge clk);
        #2;
        check("R9 valid", int'(out_valid), 0);
        check("R9 sample", int'(out_sample), 0);
        @(negedge clk);
        rst = 1'b0;
        m_prev = 0; m_step = 127; last_out = 0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R1 nibble selection, distinct codes in each half
        step(8'h35, 1'b0, 1'b1, 1'b0, "R1 low");
        step(8'h35, 1'b1, 1'b1, 1'b0, "R1 high");
        step(8'hC2, 1'b1, 1'b1, 1'b0, "R1 neg high");
        // R8 idle holds output and state
        step(8'h77, 1'b0, 1'b0, 1'b0, "R8 idle");
        step(8'h04, 1'b0, 1'b1, 1'b0, "R8 after idle");
        // R6 restart beats a code
        step(8'h07, 1'b0, 1'b1, 1'b1, "R6 restart");
        step(8'h01, 1'b0, 1'b1, 1'b0, "R6 first code");
        // R3 positive saturation, R5 step ceiling
        for (int i = 0; i < 14; i++) step(8'h07, 1'b0, 1'b1, 1'b0, "R3 up");
        // R2 capped difference and negative saturation
        for (int i = 0; i < 4; i++) step(8'hF0, 1'b1, 1'b1, 1'b0, "R2 down");
        step(8'h07, 1'b0, 1'b1, 1'b0, "R2 cap from floor");
        // R5 step floor with index 0 codes
        step(8'h00, 1'b0, 1'b0, 1'b1, "R5 restart");
        for (int i = 0; i < 10; i++) step(8'h00, 1'b0, 1'b1, 1'b0, "R5 floor");
        // R4 growth then shrink
        step(8'h00, 1'b0, 1'b0, 1'b1, "R4 restart");
        step(8'h04, 1'b0, 1'b1, 1'b0, "R4 idx4");
        step(8'h05, 1'b0, 1'b1, 1'b0, "R4 idx5");
        step(8'h06, 1'b0, 1'b1, 1'b0, "R4 idx6");
        step(8'h0B, 1'b0, 1'b1, 1'b0, "R4 idx3 neg");
        // R7 random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] b = 8'($urandom);
            logic o  = 1'($urandom);
            logic v  = ($urandom % 4) != 0;
            logic rs = ($urandom % 64) == 0;
            step(b, o, v, rs, "R7 random");
        end
        // R9 reset in mid stream
        do_reset();
        step(8'h60, 1'b1, 1'b1, 1'b0, "R9 after reset");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule